// File: doc/BRIEF.md
# Codec Input Frame Slot Formatter

This block assembles the parallel contents of the frame a codec returns to its controller on a serial audio link. Each frame has a 16-bit tag slot followed by twelve 20-bit data slots. On a one-cycle frame strobe the block latches every slot word and every tag bit at the same time. It then holds them for the serial shifter until the next strobe.

Register reads are answered one frame late. A read address decoded during a frame is held as pending. At the next strobe the block echoes that address in slot 1 and places the register contents, fetched through a combinational register-file read port, in slot 2.

Capture samples from six converters are 18-bit two's complement values. They are routed into capture slots under a 2-bit mode field. A slot's tag bit is set only when a converter is routed there and that converter flags its sample as valid.

Top module: `codec_slot_fmt`

## Requirements
- R1: While reset is asserted, `tag_slot` and `slot_words` are all zero.
- R2: `tag_slot` and `slot_words` change only on the clock edge where `frame_start` is high, and hold their value otherwise.
- R3: A read requested (`rd_req` high with `rd_addr`) between two strobes is answered at the following strobe. Tag bits 14 and 13 (slots 1 and 2) are set. Slot 1, which is `slot_words[19:0]`, carries the address in bits 18:12 and zeros elsewhere.
- R4: For an answered read, slot 2 (`slot_words[39:20]`) carries in bits 19:16.. 19:4 the value of `rf_data` while `rf_addr` equals the pending address during the strobe cycle. Slot 2 bits 3:0 are zero.
- R5: At a strobe with no read pending, tag bits 14 and 13 are zero and slots 1 and 2 are zero. Each request is answered only once.
- R6: A request in the same cycle as a strobe belongs to the new frame and is answered at the following strobe. When several requests arrive in one frame, the last one is answered.
- R7: A capture slot carries its sample in bits 19:2, with bits 1:0 zero. Its tag bit (bit 15−s for slot s) is set only when a converter is routed to it and that converter's `conv_valid` bit is high. A slot whose tag is clear reads as zero.
- R8: Mode 0 routes converter 0 to slot 3 and converter 1 to slot 4.
- R9: Mode 1 routes converters 0 to 5 to slots 3, 4, 6, 7, 8 and 11 in that order.
- R10: Mode 2 routes converter 0 to slot 6 and converter 1 to slot 11.
- R11: Mode 3 routes no converter, so all capture tag bits are zero.
- R12: Tag bit 15 is `codec_ready` sampled at the strobe. Tag bits 2:0 are always zero. Slots 5, 9, 10 and 12 always have clear tags and zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe that latches all slot words |
| codec_ready | input | 1 | Ready flag copied to tag bit 15 |
| rd_req | input | 1 | Register read request decoded from the outgoing frame |
| rd_addr | input | 7 | Address of the requested register |
| rf_addr | output | 7 | Register-file read address (the pending address) |
| rf_data | input | 16 | Register-file read data, combinational from `rf_addr` |
| cap_mode | input | 2 | Converter-to-slot routing mode |
| conv_data | input | 108 | Six 18-bit samples; converter c at bits 18c+17:18c |
| conv_valid | input | 6 | Per-converter sample valid |
| tag_slot | output | 16 | Slot 0 tag word |
| slot_words | output | 240 | Slots 1 to 12; slot s at bits 20s−1:20(s−1) |

## Verification
Every slot result is due one clock edge after the cycle in which `frame_start` is high. The stimulus behind it is the mode, valid bits, samples and ready flag present in that strobe cycle, plus the read pending from the frame before. A read answer is therefore due at the second strobe after its request, or the first strobe after it when the request falls strictly between strobes. The driver drives inputs on the falling edge and pushes the expected frame before raising the strobe. The monitor flags each strobe at the rising edge and compares at the next falling edge. On every falling edge in between, it confirms that the outputs still match the last frame.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
  localparam int SLOT_W = 20;
  localparam int NSLOT  = 12;
  localparam int SAMP_W = 18;
  localparam int RDAT_W = 16;
  localparam int ADDR_W = 7;
  localparam int NCONV  = 6;
  localparam int TAG_W  = 16;

  typedef struct packed {
    logic       hit;
    logic [2:0] idx;
  } route_t;

  // converter feeding a given slot (1-based) under a routing mode
  function automatic route_t route_of(input logic [1:0] mode, input int slot);
    route_t r;
    r.hit = 1'b0;
    r.idx = 3'd0;
    case (mode)
      2'd0: begin
        if (slot == 3) r = '{1'b1, 3'd0};
        if (slot == 4) r = '{1'b1, 3'd1};
      end
      2'd1: begin
        if (slot == 3)  r = '{1'b1, 3'd0};
        if (slot == 4)  r = '{1'b1, 3'd1};
        if (slot == 6)  r = '{1'b1, 3'd2};
        if (slot == 7)  r = '{1'b1, 3'd3};
        if (slot == 8)  r = '{1'b1, 3'd4};
        if (slot == 11) r = '{1'b1, 3'd5};
      end
      2'd2: begin
        if (slot == 6)  r = '{1'b1, 3'd0};
        if (slot == 11) r = '{1'b1, 3'd1};
      end
      default: r.hit = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sfmt_read_path.sv
module sfmt_read_path
  import sfmt_pkg::*;
#(
  parameter int ADDR_W_P = ADDR_W,
  parameter int RDAT_W_P = RDAT_W,
  parameter int SLOT_W_P = SLOT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                rd_req,
  input  logic [ADDR_W_P-1:0] rd_addr,
  input  logic [RDAT_W_P-1:0] rf_data,
  output logic [ADDR_W_P-1:0] rf_addr,
  output logic                rd_pend,
  output logic [SLOT_W_P-1:0] s1_word,
  output logic [SLOT_W_P-1:0] s2_word
);
  localparam int S1_LO = SLOT_W_P - 1 - ADDR_W_P;
  localparam int S2_LO = SLOT_W_P - RDAT_W_P;

  logic                pend_q, pend_d;
  logic [ADDR_W_P-1:0] addr_q, addr_d;
  logic                pend_en;

  assign pend_en = frame_start | rd_req;

  always_comb begin
    pend_d = pend_q;
    addr_d = addr_q;
    if (rd_req) begin
      pend_d = 1'b1;
      addr_d = rd_addr;
    end else if (frame_start) begin
      pend_d = 1'b0;
      addr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
      addr_q <= addr_d;
    end
  end

  assign rf_addr = addr_q;
  assign rd_pend = pend_q;
  assign s1_word = pend_q ? {1'b0, addr_q, {S1_LO{1'b0}}} : '0;
  assign s2_word = pend_q ? {rf_data, {S2_LO{1'b0}}} : '0;

  // R6
  rd_newframe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && rd_req |=> pend_q && (rf_addr == $past(rd_addr)));
  // R5
  rd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !rd_req |=> !pend_q);
endmodule

// File: rtl/sfmt_cap_route.sv
module sfmt_cap_route
  import sfmt_pkg::*;
#(
  parameter int NCONV_P  = NCONV,
  parameter int SAMP_W_P = SAMP_W,
  parameter int SLOT_W_P = SLOT_W,
  parameter int NSLOT_P  = NSLOT
) (
  input  logic [1:0]                  mode,
  input  logic [NCONV_P*SAMP_W_P-1:0] conv_data,
  input  logic [NCONV_P-1:0]          conv_valid,
  output logic [NSLOT_P*SLOT_W_P-1:0] cap_words,
  output logic [NSLOT_P-1:0]          cap_vld
);
  localparam int PAD_W = SLOT_W_P - SAMP_W_P;

  logic [SAMP_W_P-1:0] samp [NCONV_P];

  for (genvar c = 0; c < NCONV_P; c++) begin : g_conv
    assign samp[c] = conv_data[c*SAMP_W_P +: SAMP_W_P];
  end

  for (genvar s = 0; s < NSLOT_P; s++) begin : g_slot
    route_t r;
    always_comb r = route_of(mode, s + 1);
    assign cap_vld[s] = r.hit && conv_valid[r.idx];
    assign cap_words[s*SLOT_W_P +: SLOT_W_P] =
      cap_vld[s] ? {samp[r.idx], {PAD_W{1'b0}}} : '0;
  end
endmodule

// File: rtl/codec_slot_fmt.sv
module codec_slot_fmt
  import sfmt_pkg::*;
#(
  parameter int SLOT_W_P = SLOT_W,
  parameter int NSLOT_P  = NSLOT,
  parameter int SAMP_W_P = SAMP_W,
  parameter int RDAT_W_P = RDAT_W,
  parameter int ADDR_W_P = ADDR_W,
  parameter int NCONV_P  = NCONV
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          codec_ready,
  input  logic                          rd_req,
  input  logic [ADDR_W_P-1:0]           rd_addr,
  output logic [ADDR_W_P-1:0]           rf_addr,
  input  logic [RDAT_W_P-1:0]           rf_data,
  input  logic [1:0]                    cap_mode,
  input  logic [NCONV_P*SAMP_W_P-1:0]   conv_data,
  input  logic [NCONV_P-1:0]            conv_valid,
  output logic [TAG_W-1:0]              tag_slot,
  output logic [NSLOT_P*SLOT_W_P-1:0]   slot_words
);
  localparam int WORDS_W = NSLOT_P * SLOT_W_P;

  logic                rd_pend;
  logic [SLOT_W_P-1:0] s1_w, s2_w;
  logic [WORDS_W-1:0]  cap_w;
  logic [NSLOT_P-1:0]  cap_v;
  logic [TAG_W-1:0]    tag_d, tag_q;
  logic [WORDS_W-1:0]  words_d, words_q;

  sfmt_read_path #(
    .ADDR_W_P(ADDR_W_P), .RDAT_W_P(RDAT_W_P), .SLOT_W_P(SLOT_W_P)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .rd_req(rd_req), .rd_addr(rd_addr), .rf_data(rf_data),
    .rf_addr(rf_addr), .rd_pend(rd_pend), .s1_word(s1_w), .s2_word(s2_w)
  );

  sfmt_cap_route #(
    .NCONV_P(NCONV_P), .SAMP_W_P(SAMP_W_P), .SLOT_W_P(SLOT_W_P), .NSLOT_P(NSLOT_P)
  ) u_cap (
    .mode(cap_mode), .conv_data(conv_data), .conv_valid(conv_valid),
    .cap_words(cap_w), .cap_vld(cap_v)
  );

  always_comb begin
    tag_d   = tag_q;
    words_d = words_q;
    if (frame_start) begin
      words_d                     = cap_w;
      words_d[0 +: SLOT_W_P]        = s1_w;
      words_d[SLOT_W_P +: SLOT_W_P] = s2_w;
      tag_d                       = '0;
      tag_d[TAG_W-1]              = codec_ready;
      tag_d[TAG_W-2]              = rd_pend;
      tag_d[TAG_W-3]              = rd_pend;
      for (int s = 3; s <= NSLOT_P; s++) tag_d[TAG_W-1-s] = cap_v[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= '0;
      words_q <= '0;
    end else if (frame_start) begin
      tag_q   <= tag_d;
      words_q <= words_d;
    end
  end

  assign tag_slot   = tag_q;
  assign slot_words = words_q;

  // R2
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(tag_slot) && $stable(slot_words));
  // R3
  rd_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && rd_pend |=> tag_slot[14] && tag_slot[13] &&
      (slot_words[18:12] == $past(rf_addr)) && !slot_words[19] &&
      (slot_words[11:0] == 12'd0));
  // R4
  rd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && rd_pend |=> (slot_words[39:24] == $past(rf_data)) &&
      (slot_words[23:20] == 4'd0));
  // R5
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !rd_pend |=> (tag_slot[14:13] == 2'b00) &&
      (slot_words[39:0] == 40'd0));
  // R11
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && (cap_mode == 2'd3) |=> ((tag_slot & 16'h1B90) == 16'h0000));
  // R12
  fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_slot[2:0] == 3'd0) && !tag_slot[10] && !tag_slot[6] &&
      !tag_slot[5] && !tag_slot[3]);

  for (genvar s = 0; s < NSLOT_P; s++) begin : g_chk
    // R7
    slot_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_words[s*SLOT_W_P +: 2] == 2'b00);
    // R7
    slot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tag_slot[TAG_W-2-s] |-> (slot_words[s*SLOT_W_P +: SLOT_W_P] == '0));
  end
endmodule

// File: tb/sim_codec_slot_fmt.sv
`timescale 1ns/1ps
module sim_codec_slot_fmt;
  logic         clk = 1'b0;
  logic         rst_n, frame_start, codec_ready, rd_req;
  logic [6:0]   rd_addr, rf_addr;
  logic [15:0]  rf_data;
  logic [1:0]   cap_mode;
  logic [107:0] conv_data;
  logic [5:0]   conv_valid;
  logic [15:0]  tag_slot;
  logic [239:0] slot_words;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  codec_slot_fmt u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .codec_ready(codec_ready),
    .rd_req(rd_req), .rd_addr(rd_addr), .rf_addr(rf_addr), .rf_data(rf_data),
    .cap_mode(cap_mode), .conv_data(conv_data), .conv_valid(conv_valid),
    .tag_slot(tag_slot), .slot_words(slot_words)
  );

  function automatic logic [15:0] rf_model(input logic [6:0] a);
    return {a, a[3:0], 5'h15} ^ 16'h3C00;
  endfunction
  assign rf_data = rf_model(rf_addr);

  // routing table per R8..R11
  function automatic int exp_src(input logic [1:0] m, input int s);
    case (m)
      2'd0: return (s == 3) ? 0 : (s == 4) ? 1 : -1;
      2'd1: case (s) 3: return 0; 4: return 1; 6: return 2; 7: return 3;
                     8: return 4; 11: return 5; default: return -1; endcase
      2'd2: return (s == 6) ? 0 : (s == 11) ? 1 : -1;
      default: return -1;
    endcase
  endfunction

  logic [15:0]  exp_tag_q[$];
  logic [239:0] exp_words_q[$];
  string        exp_note_q[$];
  logic [15:0]  last_tag = '0;
  logic [239:0] last_words = '0;
  bit           m_pend = 0;
  logic [6:0]   m_addr = '0;
  bit           fs_seen = 0;
  bit           mon_on = 0;

  task automatic fail_if(input bit bad, input string req, input string what,
                         input logic [239:0] act, input logic [239:0] exp);
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic strobe(input logic [1:0] m, input logic rdy, input logic [5:0] v,
                        input logic req_now, input logic [6:0] a, input string note);
    logic [15:0]  et;
    logic [239:0] ew;
    int src;
    @(negedge clk);
    cap_mode = m; codec_ready = rdy; conv_valid = v;
    et = '0; ew = '0; et[15] = rdy;
    if (m_pend) begin
      et[14] = 1'b1; et[13] = 1'b1;
      ew[18:12] = m_addr;
      ew[39:24] = rf_model(m_addr);
    end
    for (int s = 3; s <= 12; s++) begin
      src = exp_src(m, s);
      if (src >= 0 && v[src]) begin
        et[15-s] = 1'b1;
        ew[(s-1)*20+2 +: 18] = conv_data[src*18 +: 18];
      end
    end
    exp_tag_q.push_back(et); exp_words_q.push_back(ew); exp_note_q.push_back(note);
    frame_start = 1'b1; rd_req = req_now; rd_addr = a;
    m_pend = req_now; m_addr = req_now ? a : 7'd0;
    @(negedge clk);
    frame_start = 1'b0; rd_req = 1'b0;
    conv_data = ~conv_data ^ {6{18'h15A3C}};
  endtask

  task automatic mid_req(input logic [6:0] a);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; m_pend = 1; m_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  always @(posedge clk) fs_seen <= frame_start;

  always @(negedge clk) begin
    if (mon_on) begin
      if (fs_seen) begin
        if (exp_tag_q.size() == 0) begin
          fail_if(1'b1, "R2", "unexpected frame", {224'd0, tag_slot}, 240'd0);
        end else begin
          logic [15:0]  et;
          logic [239:0] ew;
          string n;
          et = exp_tag_q.pop_front(); ew = exp_words_q.pop_front(); n = exp_note_q.pop_front();
          fail_if(tag_slot !== et, {"R12 ", n}, "tag", {224'd0, tag_slot}, {224'd0, et});
          for (int s = 1; s <= 12; s++)
            fail_if(slot_words[(s-1)*20 +: 20] !== ew[(s-1)*20 +: 20],
                    s == 1 ? {"R3 ", n} : s == 2 ? {"R4 ", n} : {"R7 ", n},
                    $sformatf("slot%0d", s),
                    {220'd0, slot_words[(s-1)*20 +: 20]}, {220'd0, ew[(s-1)*20 +: 20]});
          last_tag = et; last_words = ew;
        end
      end else begin
        fail_if((tag_slot !== last_tag) || (slot_words !== last_words), "R2", "hold",
                slot_words, last_words);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; codec_ready = 1'b0; rd_req = 1'b0;
    rd_addr = '0; cap_mode = 2'd0; conv_valid = '0;
    for (int c = 0; c < 6; c++) conv_data[c*18 +: 18] = 18'h01234 + 18'(c * 18'h0A5B7);
    repeat (3) @(negedge clk);
    // R1 reset state
    fail_if(tag_slot !== 16'd0, "R1", "reset tag", {224'd0, tag_slot}, 240'd0);
    fail_if(slot_words !== 240'd0, "R1", "reset slots", slot_words, 240'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;
    strobe(2'd0, 1'b1, 6'h3F, 1'b0, 7'd0, "R8 R5");
    repeat (3) @(negedge clk);
    mid_req(7'h26);
    strobe(2'd1, 1'b1, 6'h3F, 1'b0, 7'd0, "R9");
    repeat (2) @(negedge clk);
    strobe(2'd1, 1'b0, 6'h3F, 1'b0, 7'd0, "R5 R12");
    strobe(2'd2, 1'b1, 6'h3F, 1'b1, 7'h7F, "R10 R6");
    repeat (2) @(negedge clk);
    strobe(2'd1, 1'b1, 6'b101010, 1'b0, 7'd0, "R6 R7");
    mid_req(7'h01);
    mid_req(7'h55);
    strobe(2'd3, 1'b1, 6'h3F, 1'b0, 7'd0, "R11 R6");
    @(negedge clk);
    conv_data[0 +: 18] = 18'h20000;
    conv_data[18 +: 18] = 18'h1FFFF;
    strobe(2'd0, 1'b1, 6'b000010, 1'b0, 7'd0, "R7 R8");
    conv_data[0 +: 18] = 18'h3FFFF;
    conv_data[18 +: 18] = 18'h20000;
    mid_req(7'h00);
    strobe(2'd2, 1'b1, 6'h3F, 1'b0, 7'd0, "R10 R3");
    strobe(2'd1, 1'b1, 6'h00, 1'b0, 7'd0, "R7 R5");
    repeat (3) @(negedge clk);
    if (exp_tag_q.size() != 0)
      fail_if(1'b1, "R2", "missing frames", 240'(exp_tag_q.size()), 240'd0);
    finish_run();
  end
endmodule